// File: doc/BRIEF.md
# Offset-Word Prescaler With Fixed High Pulse

This block is a programmable prescaler for a fast input clock. A 9-bit divide word sets the ratio, which is the word plus eight, so the legal words 4 to 511 give ratios from 12 up to 519. Once per period the block raises a one-cycle terminal-count strobe, meant to enable a post divider that follows it. It also drives its own output clock. That output is high for exactly eight input cycles at the start of each period and low for the rest.

The divide word is sampled only on the strobe cycle, so a change made in the middle of a period takes effect in the next period. A word below 4 is refused. The block keeps dividing by the last word it accepted, and an error flag shows that the word at the input is illegal. The counter is an up-counter compared against a pre-offset limit register. This keeps the per-cycle logic to one increment and one equality test, so the block can run at a higher input rate than a slower 7-bit divider.

Top module: `opw_prescaler`

## Requirements
- R1: After reset is released, the first period is the reset-default ratio of 12 input cycles (default word 4), with `clk_o` high and `tc_o` low in its first cycle.
- R2: For a legal word W (4 to 511, unsigned binary on `word_i`), the output period is W+8 input cycles. For example, word 276 (binary 100010100) gives 284.
- R3: `tc_o` is high for exactly one input cycle per period, in the last cycle of the period.
- R4: `clk_o` is high for exactly 8 input cycles per period, and these are the first 8 cycles after each `tc_o` cycle.
- R5: `word_i` is sampled only in the `tc_o` cycle. A word change in any other cycle leaves the current period unchanged and takes effect in the period that follows the next `tc_o`.
- R6: A word value of 0, 1, 2 or 3 sampled in a `tc_o` cycle is ignored, and the ratio stays at the last accepted word.
- R7: `err_o` is high in the cycle after `word_i` holds a value of 0 to 3, and low in the cycle after it holds a legal value. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 9 | Divide word; ratio is word plus 8 |
| tc_o | output | 1 | One-cycle strobe on the last cycle of each period |
| clk_o | output | 1 | Divided clock, high for the first 8 cycles of each period |
| err_o | output | 1 | Registered flag: input word is below 4 |

## Verification
Assertions check on every cycle that:
- the counter never passes the limit;
- the strobe lasts one cycle and is followed by a high output;
- the output falls only at count eight;
- the limit changes only on a strobe, and never takes an illegal word.

Only the bench scenarios can show the absolute period length for each word. They also show the deferral of a mid-period word change to the following period, the retention of the previous ratio across a refused word, and the length of the first period after reset.

// File: rtl/opw_pkg.sv
package opw_pkg;
  localparam int WORD_W   = 9;
  localparam int OFFSET   = 8;
  localparam int HIGH_CYC = 8;
  localparam int MIN_WORD = 4;
  localparam int RST_WORD = 4;
endpackage

// File: rtl/opw_word_gate.sv
module opw_word_gate #(
  parameter int WORD_W   = opw_pkg::WORD_W,
  parameter int OFFSET   = opw_pkg::OFFSET,
  parameter int MIN_WORD = opw_pkg::MIN_WORD,
  parameter int RST_WORD = opw_pkg::RST_WORD,
  localparam int CNT_W   = WORD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  lim_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(RST_WORD + OFFSET - 1);
  localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(MIN_WORD + OFFSET - 1);

  logic legal;
  assign legal = (word_i >= WORD_W'(MIN_WORD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_o <= LIM_RST;
      err_o <= 1'b0;
    end else begin
      err_o <= ~legal;
      if (load_i && legal) lim_o <= CNT_W'(word_i) + CNT_W'(OFFSET - 1);
    end
  end

  // R5
  lim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(lim_o));
  // R6
  lim_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && err_o == 1'b0 && word_i < WORD_W'(MIN_WORD)) |=> $stable(lim_o));
  // R6
  lim_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_o >= LIM_MIN);
endmodule

// File: rtl/opw_counter.sv
module opw_counter #(
  parameter int CNT_W = opw_pkg::WORD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  assign tc_o = (cnt_o == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (tc_o) cnt_o <= '0;
    else           cnt_o <= cnt_o + CNT_W'(1);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= lim_i);
  // R3
  tc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> !tc_o);
endmodule

// File: rtl/opw_shaper.sv
module opw_shaper #(
  parameter int CNT_W    = opw_pkg::WORD_W + 1,
  parameter int HIGH_CYC = opw_pkg::HIGH_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tc_i,
  output logic             clk_o
);
  // registered so the output clock is glitch free; tracks cnt < HIGH_CYC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_o <= 1'b1;
    else         clk_o <= tc_i | (cnt_i < CNT_W'(HIGH_CYC - 1));
  end

  // R4
  hi_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> clk_o);
  // R4
  hi_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_o) |-> (cnt_i == CNT_W'(HIGH_CYC)));
endmodule

// File: rtl/opw_prescaler.sv
module opw_prescaler #(
  parameter int WORD_W   = opw_pkg::WORD_W,
  parameter int OFFSET   = opw_pkg::OFFSET,
  parameter int HIGH_CYC = opw_pkg::HIGH_CYC,
  parameter int MIN_WORD = opw_pkg::MIN_WORD,
  parameter int RST_WORD = opw_pkg::RST_WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              tc_o,
  output logic              clk_o,
  output logic              err_o
);
  localparam int CNT_W = WORD_W + 1;

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;

  opw_word_gate #(
    .WORD_W(WORD_W), .OFFSET(OFFSET), .MIN_WORD(MIN_WORD), .RST_WORD(RST_WORD)
  ) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .load_i(tc_o),
    .lim_o(lim), .err_o(err_o)
  );

  opw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .lim_i(lim), .cnt_o(cnt), .tc_o(tc_o)
  );

  opw_shaper #(.CNT_W(CNT_W), .HIGH_CYC(HIGH_CYC)) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .tc_i(tc_o), .clk_o(clk_o)
  );

  // R1
  rst_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_o) |=> clk_o);
endmodule

// File: tb/opw_prescaler_tb.sv
module opw_prescaler_tb_top;
  localparam int CLK_PER = 10;
  localparam int NVEC = 6;
  localparam int WDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] word = 9'd4;
  logic       tc, clk_div, err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // {word, expected ratio}
  localparam logic [9:0] VEC_W [NVEC] = '{10'd4, 10'd276, 10'd511, 10'd5, 10'd100, 10'd12};
  localparam int         VEC_R [NVEC] = '{12, 284, 519, 13, 108, 20};

  always #(CLK_PER/2) clk = ~clk;

  opw_prescaler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word),
    .tc_o(tc), .clk_o(clk_div), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tc();
    do @(negedge clk); while (!tc);
  endtask

  // measure one period following the current tc cycle
  task automatic measure(output int n, output int hi, output int ntc,
                         output int first_hi, input int chg_at, input logic [8:0] chg_w);
    n = 0; hi = 0; ntc = 0; first_hi = 0;
    do begin
      @(negedge clk);
      n++;
      if (clk_div) hi++;
      if (clk_div && n <= 8) first_hi++;
      if (tc) ntc++;
      if (n == chg_at) word = chg_w;
    end while (!tc);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n, hi, ntc, fh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and first period
    chk("R1 clk_o", clk_div, 1);
    chk("R1 tc_o", tc, 0);
    chk("R7 err reset", err, 0);
    n = 1;
    while (!tc) begin @(negedge clk); n++; end
    chk("R1 first period", n, 12);

    for (int i = 0; i < NVEC; i++) begin
      word = VEC_W[i][8:0];
      wait_tc();
      measure(n, hi, ntc, fh, 0, 9'd0);
      chk("R2 period", n, VEC_R[i]);
      chk("R4 high count", hi, 8);
      chk("R4 high at start", fh, 8);
      chk("R3 strobe count", ntc, 1);
    end

    // R5 mid-period change deferred
    word = 9'd30;
    wait_tc();
    measure(n, hi, ntc, fh, 5, 9'd40);
    chk("R5 current period kept", n, 38);
    measure(n, hi, ntc, fh, 0, 9'd0);
    chk("R5 new word next period", n, 48);

    // R6/R7 illegal words held off
    for (int w = 0; w < 4; w++) begin
      word = 9'(w);
      @(negedge clk);
      chk("R7 err on illegal", err, 1);
      wait_tc();
      measure(n, hi, ntc, fh, 0, 9'd0);
      chk("R6 ratio held", n, 48);
    end
    word = 9'd4;
    @(negedge clk);
    chk("R7 err clears", err, 0);
    wait_tc();
    measure(n, hi, ntc, fh, 0, 9'd0);
    chk("R6 legal after illegal", n, 12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule